// File: doc/BRIEF.md
# CORDIC Interval Restore and Single-Precision Packer

This block sits at the output of a multi-mode CORDIC core. The core hands over three 25-bit signed fixed-point paths: one sign bit, one integer bit and 23 fraction bits, so the value is the integer divided by 2^23. With them come the coordinate-system select, a 3-bit interval code and one precomputed exponent per path.

For trigonometric work, the coordinate select is 00. In that case the block undoes the earlier angle folding. It swaps and negates the X and Y paths, and it puts back a π/2 or π offset on the Z path. For every other coordinate system, the three paths pass through unchanged and carry their own exponents.

After that step, each path is converted to an IEEE-754 single-precision word. The conversion takes the magnitude, finds its leading one, left-aligns the fraction with truncation, and adjusts the exponent to match.

The block has two pipeline stages. Stage 1 registers the restored paths. Stage 2 registers the packed words. A valid flag travels alongside the data.

Top module: `quad_float_pack`

## Requirements
- R1: `out_valid` rises two clock edges after an accepted `in_valid` and falls two edges after `in_valid` is low; after reset `out_valid` is 0 and all three words are 0.
- R2: When `coord_sel` is not 00, all three paths pass unchanged whatever `band_code` holds, and each path's exponent base is its own `*_exp` input.
- R3: With `coord_sel`=00 and `band_code`=000, the paths pass unchanged and every exponent base is 127.
- R4: With `coord_sel`=00 and `band_code`=001, X becomes -Y, Y becomes X, and Z gains π/2, taken as 13176795 units of 2^-23.
- R5: With `coord_sel`=00 and `band_code`=010, X and Y are both negated and Z gains π, taken as 26353589 units of 2^-23.
- R6: With `coord_sel`=00 and `band_code`=011, X and Y are both negated and π (26353589 units) is subtracted from Z.
- R7: With `coord_sel`=00 and `band_code`=100, X becomes Y, Y becomes -X, and π/2 (13176795 units) is subtracted from Z.
- R8: With `coord_sel`=00 and `band_code` 101, 110 or 111, the paths pass unchanged with exponent base 127.
- R9: A nonzero magnitude M, with its leading one at bit p, packs as word bit 31 = sign, bits 30:23 = base + p - 23 (low 8 bits), and bits 22:0 = the bits of M below the leading one, left-aligned and truncated.
- R10: A negative path value packs with sign bit 1 and uses its two's-complement magnitude. The most negative input, -2^24, gives magnitude 2^24, and its negation gives a positive value.
- R11: A path that is zero after restoring packs as 32'h00000000 (+0.0); negative zero never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input set is valid this cycle |
| coord_sel | input | 2 | Coordinate system; 00 selects trigonometric restoring |
| band_code | input | 3 | Interval code from the folding stage |
| x_fix | input | 25 | X path, signed fixed point, 23 fraction bits |
| y_fix | input | 25 | Y path, signed fixed point, 23 fraction bits |
| z_fix | input | 25 | Z path, signed fixed point, 23 fraction bits |
| x_exp | input | 8 | X exponent base for non-trigonometric work |
| y_exp | input | 8 | Y exponent base for non-trigonometric work |
| z_exp | input | 8 | Z exponent base for non-trigonometric work |
| out_valid | output | 1 | Result words valid |
| x_word | output | 32 | X result, single precision |
| y_word | output | 32 | Y result, single precision |
| z_word | output | 32 | Z result, single precision |

## Verification
Two things can land in the same cycle. One is a path swap with negation. The other is a magnitude corner inside the normaliser: most negative input, zero, a single LSB, or all ones. When a swap brings -2^24 or zero into a path, both the restoring step and the leading-one logic act on the same value at once.

The bench creates these collisions on purpose. It feeds such values to the path that is swapped or negated under each interval code, and it does so back to back with no idle cycles. A behavioural model compares every cycle's valid flag and all three words. The model uses plain integer arithmetic, so the expected words never come from the design's own structure.

// File: rtl/qfp_pkg.sv
package qfp_pkg;

   localparam int QFP_PATHS = 3;

   typedef enum logic [2:0] {
      BAND_DIRECT     = 3'd0,
      BAND_PLUS_HALF  = 3'd1,
      BAND_PLUS_PI    = 3'd2,
      BAND_MINUS_PI   = 3'd3,
      BAND_MINUS_HALF = 3'd4
   } band_e;

   typedef enum int {
      PATH_X = 0,
      PATH_Y = 1,
      PATH_Z = 2
   } path_e;

endpackage

// File: rtl/qfp_lead_one.sv
module qfp_lead_one #(
   parameter int W     = 27,
   parameter int POS_W = 5
) (
   input  logic [W-1:0]     vec,
   output logic [POS_W-1:0] pos,
   output logic             found
);

   always_comb begin
      pos = '0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) pos = POS_W'(i);
      end
   end

   assign found = |vec;

endmodule

// File: rtl/qfp_band_undo.sv
module qfp_band_undo
   import qfp_pkg::*;
#(
   parameter int FIX_W    = 25,
   parameter int FRAC_W   = 23,
   parameter int GUARD_W  = 2,
   parameter int EXP_W    = 8,
   parameter int EXP_BIAS = 127,
   localparam int IW      = FIX_W + GUARD_W
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic [1:0]                      coord_sel,
   input  logic [2:0]                      band_code,
   input  logic [FIX_W-1:0]                x_fix,
   input  logic [FIX_W-1:0]                y_fix,
   input  logic [FIX_W-1:0]                z_fix,
   input  logic [EXP_W-1:0]                x_exp,
   input  logic [EXP_W-1:0]                y_exp,
   input  logic [EXP_W-1:0]                z_exp,
   output logic                            s1_valid,
   output logic [QFP_PATHS-1:0][IW-1:0]    s1_val,
   output logic [QFP_PATHS-1:0][EXP_W-1:0] s1_base
);

   localparam real PI_R     = 3.14159265358979323846;
   localparam int  PI_INT   = $rtoi(PI_R * (2.0 ** FRAC_W) + 0.5);
   localparam int  HALF_INT = $rtoi(PI_R * (2.0 ** (FRAC_W - 1)) + 0.5);
   localparam logic signed [IW-1:0] PI_Q   = IW'(PI_INT);
   localparam logic signed [IW-1:0] HALF_Q = IW'(HALF_INT);

   logic signed [IW-1:0] xe, ye, ze;
   logic signed [IW-1:0] nx, ny, nz;
   logic [EXP_W-1:0]     bx, by, bz;
   logic                 trig;

   assign trig = (coord_sel == 2'b00);

   always_comb begin
      xe = {{GUARD_W{x_fix[FIX_W-1]}}, x_fix};
      ye = {{GUARD_W{y_fix[FIX_W-1]}}, y_fix};
      ze = {{GUARD_W{z_fix[FIX_W-1]}}, z_fix};
      nx = xe;
      ny = ye;
      nz = ze;
      if (trig) begin
         case (band_e'(band_code))
            BAND_PLUS_HALF: begin
               nx = -ye;
               ny = xe;
               nz = ze + HALF_Q;
            end
            BAND_PLUS_PI: begin
               nx = -xe;
               ny = -ye;
               nz = ze + PI_Q;
            end
            BAND_MINUS_PI: begin
               nx = -xe;
               ny = -ye;
               nz = ze - PI_Q;
            end
            BAND_MINUS_HALF: begin
               nx = ye;
               ny = -xe;
               nz = ze - HALF_Q;
            end
            default: begin
               nx = xe;
               ny = ye;
               nz = ze;
            end
         endcase
      end
   end

   assign bx = trig ? EXP_W'(EXP_BIAS) : x_exp;
   assign by = trig ? EXP_W'(EXP_BIAS) : y_exp;
   assign bz = trig ? EXP_W'(EXP_BIAS) : z_exp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_val   <= '0;
         s1_base  <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_val  <= {nz, ny, nx};
            s1_base <= {bz, by, bx};
         end
      end
   end

endmodule

// File: rtl/qfp_pack.sv
module qfp_pack #(
   parameter int IW     = 27,
   parameter int FRAC_W = 23,
   parameter int EXP_W  = 8,
   parameter int MANT_W = 23,
   localparam int WORD_W = 1 + EXP_W + MANT_W
) (
   input  logic [IW-1:0]     val,
   input  logic [EXP_W-1:0]  base,
   output logic [WORD_W-1:0] word
);

   localparam int POS_W = $clog2(IW);
   localparam int SUM_W = EXP_W + POS_W + 1;

   logic              neg;
   logic [IW-1:0]     mag;
   logic [POS_W-1:0]  lead;
   logic              found;
   logic [POS_W-1:0]  shamt;
   logic [IW-1:0]     norm;
   logic [MANT_W-1:0] mant;
   logic [EXP_W-1:0]  efield;

   assign neg = val[IW-1];
   assign mag = neg ? (~val + IW'(1)) : val;

   qfp_lead_one #(
      .W     (IW),
      .POS_W (POS_W)
   ) u_lead (
      .vec   (mag),
      .pos   (lead),
      .found (found)
   );

   assign shamt  = POS_W'(IW - 1) - lead;
   assign norm   = mag << shamt;
   assign mant   = MANT_W'(norm >> (IW - 1 - MANT_W));
   assign efield = EXP_W'(SUM_W'(base) + SUM_W'(lead) - SUM_W'(FRAC_W));
   assign word   = found ? {neg, efield, mant} : '0;

endmodule

// File: rtl/quad_float_pack.sv
module quad_float_pack
   import qfp_pkg::*;
#(
   parameter int FIX_W    = 25,
   parameter int FRAC_W   = 23,
   parameter int GUARD_W  = 2,
   parameter int EXP_W    = 8,
   parameter int MANT_W   = 23,
   parameter int EXP_BIAS = 127
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [1:0]                coord_sel,
   input  logic [2:0]                band_code,
   input  logic [FIX_W-1:0]          x_fix,
   input  logic [FIX_W-1:0]          y_fix,
   input  logic [FIX_W-1:0]          z_fix,
   input  logic [EXP_W-1:0]          x_exp,
   input  logic [EXP_W-1:0]          y_exp,
   input  logic [EXP_W-1:0]          z_exp,
   output logic                      out_valid,
   output logic [EXP_W+MANT_W:0]     x_word,
   output logic [EXP_W+MANT_W:0]     y_word,
   output logic [EXP_W+MANT_W:0]     z_word
);

   localparam int IW     = FIX_W + GUARD_W;
   localparam int WORD_W = 1 + EXP_W + MANT_W;

   if (GUARD_W < 2) begin : g_bad_guard
      $error("GUARD_W must be at least 2 to hold an angle plus pi");
   end
   if (IW - 1 < MANT_W) begin : g_bad_mant
      $error("fixed-point width too small for the mantissa field");
   end
   if (EXP_BIAS >= (2 ** EXP_W)) begin : g_bad_bias
      $error("EXP_BIAS does not fit the exponent field");
   end
   if (FRAC_W >= FIX_W) begin : g_bad_frac
      $error("FRAC_W must leave room for sign and integer bits");
   end

   logic                            s1_valid;
   logic [QFP_PATHS-1:0][IW-1:0]    s1_val;
   logic [QFP_PATHS-1:0][EXP_W-1:0] s1_base;
   logic                            valid_q;

   qfp_band_undo #(
      .FIX_W    (FIX_W),
      .FRAC_W   (FRAC_W),
      .GUARD_W  (GUARD_W),
      .EXP_W    (EXP_W),
      .EXP_BIAS (EXP_BIAS)
   ) u_undo (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .coord_sel (coord_sel),
      .band_code (band_code),
      .x_fix     (x_fix),
      .y_fix     (y_fix),
      .z_fix     (z_fix),
      .x_exp     (x_exp),
      .y_exp     (y_exp),
      .z_exp     (z_exp),
      .s1_valid  (s1_valid),
      .s1_val    (s1_val),
      .s1_base   (s1_base)
   );

   for (genvar p = 0; p < QFP_PATHS; p++) begin : g_path
      logic [WORD_W-1:0] word_c;
      logic [WORD_W-1:0] word_q;

      qfp_pack #(
         .IW     (IW),
         .FRAC_W (FRAC_W),
         .EXP_W  (EXP_W),
         .MANT_W (MANT_W)
      ) u_pack (
         .val  (s1_val[p]),
         .base (s1_base[p]),
         .word (word_c)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        word_q <= '0;
         else if (s1_valid) word_q <= word_c;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= s1_valid;
   end

   assign out_valid = valid_q;
   assign x_word    = g_path[PATH_X].word_q;
   assign y_word    = g_path[PATH_Y].word_q;
   assign z_word    = g_path[PATH_Z].word_q;

endmodule

// File: rtl/qfp_check.sv
module qfp_check #(
   parameter int FIX_W  = 25,
   parameter int EXP_W  = 8,
   parameter int MANT_W = 23,
   localparam int WORD_W = 1 + EXP_W + MANT_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        coord_sel,
   input logic [2:0]        band_code,
   input logic [FIX_W-1:0]  x_fix,
   input logic [FIX_W-1:0]  z_fix,
   input logic              out_valid,
   input logic [WORD_W-1:0] x_word,
   input logic [WORD_W-1:0] z_word
);

   assert_valid_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 out_valid);

   assert_idle_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ##1 !out_valid);

   assert_pass_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && coord_sel != 2'b00 && x_fix != '0)
      |=> ##1 (x_word[WORD_W-1] == $past(x_fix[FIX_W-1], 2)));

   assert_pass_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && coord_sel != 2'b00 && z_fix == '0) |=> ##1 (z_word == '0));

   assert_pi_negate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && coord_sel == 2'b00 && band_code == 3'd2 && x_fix != '0)
      |=> ##1 (x_word[WORD_W-1] == !$past(x_fix[FIX_W-1], 2)));

   assert_no_neg_zero_x_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && x_word[WORD_W-2:0] == '0) |-> !x_word[WORD_W-1]);

   assert_no_neg_zero_z_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && z_word[WORD_W-2:0] == '0) |-> !z_word[WORD_W-1]);

endmodule

bind quad_float_pack qfp_check #(
   .FIX_W  (FIX_W),
   .EXP_W  (EXP_W),
   .MANT_W (MANT_W)
) u_qfp_check (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .coord_sel (coord_sel),
   .band_code (band_code),
   .x_fix     (x_fix),
   .z_fix     (z_fix),
   .out_valid (out_valid),
   .x_word    (x_word),
   .z_word    (z_word)
);

// File: tb/test_quad_float_pack.sv
`timescale 1ns/1ps
module test_quad_float_pack;

   localparam longint PI_U   = 26353589;
   localparam longint HALF_U = 13176795;

   typedef struct {
      bit          v;
      logic [31:0] wx;
      logic [31:0] wy;
      logic [31:0] wz;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  coord_sel = '0;
   logic [2:0]  band_code = '0;
   logic [24:0] x_fix = '0, y_fix = '0, z_fix = '0;
   logic [7:0]  x_exp = '0, y_exp = '0, z_exp = '0;
   logic        out_valid;
   logic [31:0] x_word, y_word, z_word;

   int   checks = 0;
   int   errors = 0;
   exp_t pend[$];
   logic [31:0] rs = 32'h2545F491;

   always #2 clk = ~clk;

   quad_float_pack i_quad_float_pack (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .coord_sel(coord_sel), .band_code(band_code),
      .x_fix(x_fix), .y_fix(y_fix), .z_fix(z_fix),
      .x_exp(x_exp), .y_exp(y_exp), .z_exp(z_exp),
      .out_valid(out_valid), .x_word(x_word), .y_word(y_word), .z_word(z_word)
   );

   function automatic logic [24:0] fx(input longint v);
      return 25'(v);
   endfunction

   function automatic longint sx(input logic [24:0] v);
      return v[24] ? longint'(v) - 64'sd33554432 : longint'(v);
   endfunction

   function automatic logic [31:0] flt(input longint v, input int base);
      longint m, mant;
      int     p, e;
      bit     s;
      if (v == 0) return 32'h0;
      s = (v < 0);
      m = s ? -v : v;
      p = 0;
      while ((m >> (p + 1)) != 0) p++;
      e = base + p - 23;
      if (p >= 23) mant = (m - (64'sd1 << p)) >> (p - 23);
      else         mant = (m - (64'sd1 << p)) << (23 - p);
      return {s, e[7:0], mant[22:0]};
   endfunction

   function automatic exp_t model(input bit v, input logic [1:0] c, input logic [2:0] b,
                                  input logic [24:0] x, input logic [24:0] y, input logic [24:0] z,
                                  input logic [7:0] ex, input logic [7:0] ey, input logic [7:0] ez);
      exp_t   r;
      longint xv = sx(x), yv = sx(y), zv = sx(z);
      longint ox = xv, oy = yv, oz = zv;
      int     bx = int'(ex), by = int'(ey), bz = int'(ez);
      if (c == 2'b00) begin
         bx = 127; by = 127; bz = 127;
         case (b)
            3'd1: begin ox = -yv; oy = xv;  oz = zv + HALF_U; end
            3'd2: begin ox = -xv; oy = -yv; oz = zv + PI_U;   end
            3'd3: begin ox = -xv; oy = -yv; oz = zv - PI_U;   end
            3'd4: begin ox = yv;  oy = -xv; oz = zv - HALF_U; end
            default: ;
         endcase
      end
      r.v  = v;
      r.wx = flt(ox, bx);
      r.wy = flt(oy, by);
      r.wz = flt(oz, bz);
      r.tag = "";
      return r;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, expv);
      end
   endtask

   task automatic compare();
      exp_t h;
      if (pend.size() >= 2) begin
         h = pend.pop_front();
         chk(h.tag, "out_valid (R1)", {31'd0, out_valid}, {31'd0, h.v});
         if (h.v) begin
            chk(h.tag, "x_word", x_word, h.wx);
            chk(h.tag, "y_word", y_word, h.wy);
            chk(h.tag, "z_word", z_word, h.wz);
         end
      end
   endtask

   task automatic step(input bit v, input logic [1:0] c, input logic [2:0] b,
                       input logic [24:0] x, input logic [24:0] y, input logic [24:0] z,
                       input logic [7:0] ex, input logic [7:0] ey, input logic [7:0] ez,
                       input string tag);
      exp_t e;
      @(negedge clk);
      compare();
      in_valid = v; coord_sel = c; band_code = b;
      x_fix = x; y_fix = y; z_fix = z;
      x_exp = ex; y_exp = ey; z_exp = ez;
      e = model(v, c, b, x, y, z, ex, ey, ez);
      e.tag = tag;
      pend.push_back(e);
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] t = s;
      t = t ^ (t << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction

   function automatic logic [24:0] rval(input logic [31:0] r);
      longint m = longint'(r[23:0]) >> (r[31:27] % 25);
      return r[24] ? fx(-m) : fx(m);
   endfunction

   initial begin
      exp_t idle;
      idle.v = 1'b0; idle.wx = '0; idle.wy = '0; idle.wz = '0; idle.tag = "R1";
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      chk("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
      chk("R1", "reset x_word", x_word, 32'd0);
      chk("R1", "reset y_word", y_word, 32'd0);
      chk("R1", "reset z_word", z_word, 32'd0);
      pend.push_back(idle);
      pend.push_back(idle);

      // R3 plain trigonometric pass, base 127 (1.0 -> 3F800000)
      step(1, 2'b00, 3'd0, fx(8388608), fx(-2097152), fx(6588397), 8'd10, 8'd20, 8'd30, "R3");
      // R4..R7 interval restoring, back to back
      step(1, 2'b00, 3'd1, fx(5931642), fx(-16777216), fx(3000000), 8'd0, 8'd0, 8'd0, "R4");
      step(1, 2'b00, 3'd2, fx(-5000000), fx(1234567), fx(-4000000), 8'd0, 8'd0, 8'd0, "R5");
      step(1, 2'b00, 3'd3, fx(-16777216), fx(-1234567), fx(4000000), 8'd0, 8'd0, 8'd0, "R6");
      step(1, 2'b00, 3'd4, fx(100), fx(-7000000), fx(-6000000), 8'd0, 8'd0, 8'd0, "R7");
      // R8 unused codes pass through
      step(1, 2'b00, 3'd5, fx(-300), fx(7000000), fx(-1), 8'd50, 8'd60, 8'd70, "R8");
      step(1, 2'b00, 3'd7, fx(1), fx(-8388608), fx(16777215), 8'd5, 8'd5, 8'd5, "R8");
      // R2 non-trigonometric: code ignored, own exponents
      step(1, 2'b01, 3'd2, fx(8388608), fx(-3), fx(0), 8'd150, 8'd90, 8'd200, "R2");
      step(1, 2'b10, 3'd1, fx(-16777216), fx(4194304), fx(12345), 8'd127, 8'd64, 8'd180, "R2");
      step(1, 2'b11, 3'd4, fx(777), fx(-777), fx(-8000000), 8'd100, 8'd101, 8'd102, "R2");
      // R10 most negative input, negated and not
      step(1, 2'b00, 3'd0, fx(-16777216), fx(-1), fx(-16777216), 8'd0, 8'd0, 8'd0, "R10");
      step(1, 2'b00, 3'd2, fx(-16777216), fx(-16777216), fx(0), 8'd0, 8'd0, 8'd0, "R10");
      // R11 zeros, including a swapped zero
      step(1, 2'b00, 3'd0, fx(0), fx(0), fx(0), 8'd0, 8'd0, 8'd0, "R11");
      step(1, 2'b00, 3'd1, fx(12), fx(0), fx(-13176795), 8'd0, 8'd0, 8'd0, "R11");
      // R9 leading-one extremes
      step(1, 2'b00, 3'd0, fx(1), fx(16777215), fx(3), 8'd0, 8'd0, 8'd0, "R9");
      step(1, 2'b01, 3'd0, fx(2), fx(8388607), fx(-5), 8'd60, 8'd140, 8'd30, "R9");
      // R1 gap with junk inputs, then resume
      step(0, 2'b00, 3'd2, fx(99), fx(99), fx(99), 8'd1, 8'd1, 8'd1, "R1");
      step(0, 2'b01, 3'd1, fx(-99), fx(5), fx(7), 8'd2, 8'd2, 8'd2, "R1");
      step(1, 2'b00, 3'd3, fx(4194304), fx(-4194304), fx(-26353589), 8'd0, 8'd0, 8'd0, "R1");

      // mixed run over all codes and magnitudes
      for (int n = 0; n < 400; n++) begin
         logic [31:0] r1, r2, r3, r4;
         rs = nxt(rs); r1 = rs;
         rs = nxt(rs); r2 = rs;
         rs = nxt(rs); r3 = rs;
         rs = nxt(rs); r4 = rs;
         step(r4[3:0] != 4'd0, r4[5:4], r4[8:6], rval(r1), rval(r2), rval(r3),
              8'(40 + r4[15:9] % 7'd100), 8'(40 + r4[22:16] % 7'd100), 8'(40 + r4[29:23] % 7'd100),
              "R9");
      end

      step(0, 2'b00, 3'd0, fx(0), fx(0), fx(0), 8'd0, 8'd0, 8'd0, "R1");
      step(0, 2'b00, 3'd0, fx(0), fx(0), fx(0), 8'd0, 8'd0, 8'd0, "R1");
      step(0, 2'b00, 3'd0, fx(0), fx(0), fx(0), 8'd0, 8'd0, 8'd0, "R1");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule